// File: doc/BRIEF.md
# Dual-Bridge Chopper Current Controller

This block is the digital core that regulates winding current in a bipolar stepper motor driven by two full H-bridges. Each bridge is steered by a direction bit and a 2-bit current-level code. The block maps the code onto one of three sense-comparator trip inputs. It enables the low-side switch of the conducting leg at the start of each chopping period and disables it once the selected comparator trips. The current then recirculates through the high side until the next period begins. The analog comparators, the RC oscillator and the power transistors lie outside the block. They appear as input strobes and as four gate enables per bridge.

A single oscillator strobe `osc_tick` times both bridges. Bridge A starts its period from the strobe, and bridge B starts a fixed number of clocks later, so the two current steps do not land on the same instant. Any change of a direction input, including a short glitch, opens a break-before-make window in which all four gates of that bridge are off. When both level codes are zero, the block reports a global low-power inhibit and drives every gate off.

Top module: `chopper_pair_ctrl`

## Requirements
- R1: Level code 01 selects trip input bit 0, code 10 selects bit 1 and code 11 selects bit 2. The trip bits that are not selected have no effect on the low-side enable.
- R2: The low-side enable of bridge A rises on the second clock edge after `osc_tick` is sampled high. For bridge B it rises OFFSET_CYC clock cycles later than for bridge A.
- R3: While reset is held, and whenever both level codes are 00, `inhibit` is 1 and all eight gate enables are 0. `inhibit` is 0 as soon as either code is non-zero.
- R4: A bridge whose level code is 00 has all four gate enables off, and this does not disturb the other bridge. After the code returns to non-zero, the low side stays off until that bridge's next period start.
- R5: Gate bit 0 is the X1 high side, bit 1 the X2 high side, bit 2 the X1 low side and bit 3 the X2 low side. With direction 1 the bridge uses bits 0 and 3, and with direction 0 it uses bits 1 and 2. The high side is on whenever the bridge is active and outside a dead window. A leg never has its high side and its low side on together.
- R6: If the selected trip is sampled high at a clock edge while the low side is on, the low side is off from the next cycle. It stays off until the next period start, even after the trip drops.
- R7: A change of a direction input sampled at a clock edge turns all four gates of that bridge off for exactly DEAD_CYC cycles. A further change inside that window restarts it, and the gates then resume with the latest direction.
- R8: When a period start and the selected trip arrive at the same edge, the period start wins. The low side turns on for one cycle and is cut at the following edge if the trip is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe from the shared chopping oscillator |
| dir_a | input | 1 | Bridge A direction: 1 = current from X1 to X2 |
| lvl_a | input | 2 | Bridge A current-level code |
| trip_a | input | 3 | Bridge A comparator trips: bit 0 hold, bit 1 normal, bit 2 boost |
| dir_b | input | 1 | Bridge B direction |
| lvl_b | input | 2 | Bridge B current-level code |
| trip_b | input | 3 | Bridge B comparator trips |
| gate_a | output | 4 | Bridge A gate enables (bit map in R5) |
| gate_b | output | 4 | Bridge B gate enables |
| inhibit | output | 1 | Global low-power state indicator |

## Verification
The hardest case to reach from the ports is a trip that coincides with a period start. The stimulus gets there by holding the selected comparator high while the low side is already off and then issuing an oscillator strobe. The bench expects exactly one cycle of low-side conduction, followed by a cut. A glitch on a direction input is also hard to observe. The bench drives it by toggling the direction for a single clock, so the window restarts, and it checks that the gates stay off until DEAD_CYC cycles after the second change.

// File: rtl/chop_pkg.sv
// Shared constants for the chopper controller: level codes and gate bit map.
package chop_pkg;

    // Current-level codes presented on each bridge's level input.
    localparam logic [1:0] LVL_OFF   = 2'b00;
    localparam logic [1:0] LVL_HOLD  = 2'b01;
    localparam logic [1:0] LVL_NORM  = 2'b10;
    localparam logic [1:0] LVL_BOOST = 2'b11;

    // Gate enable bit positions inside one bridge's 4-bit vector.
    localparam int G_HI_X1 = 0;
    localparam int G_HI_X2 = 1;
    localparam int G_LO_X1 = 2;
    localparam int G_LO_X2 = 3;

    typedef logic [3:0] gate_t;

endpackage

// File: rtl/chop_phaser.sv
// Period-start generator.
// Turns the shared oscillator strobe into one start pulse per bridge. Bridge 0
// starts one clock after the strobe. Bridge 1 starts OFFSET_CYC clocks after
// bridge 0. A fresh strobe restarts the offset count.
// Assumes OFFSET_CYC >= 2 and a strobe period longer than OFFSET_CYC.
module chop_phaser #(
    parameter int OFFSET_CYC = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    output logic [1:0] start_pulse
);
    localparam int CW = $clog2(OFFSET_CYC + 1);

    logic [CW-1:0] offs_cnt;
    logic          start_a_q;
    logic          start_b_q;

    // Offset counter and registered start pulses for both bridges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offs_cnt  <= '0;
            start_a_q <= 1'b0;
            start_b_q <= 1'b0;
        end else begin
            start_a_q <= osc_tick;
            start_b_q <= (offs_cnt == CW'(1)) && !osc_tick;
            if (osc_tick)
                offs_cnt <= CW'(OFFSET_CYC);
            else if (offs_cnt != '0)
                offs_cnt <= offs_cnt - CW'(1);
        end
    end

    assign start_pulse = {start_b_q, start_a_q};

endmodule

// File: rtl/chop_dead_timer.sv
// Break-before-make window for one bridge.
// It registers the direction input. On every sampled change it loads a
// down-counter with DEAD_CYC, and the window stays open while the counter is
// non-zero. A change inside the window reloads the counter.
// Assumes DEAD_CYC >= 1.
module chop_dead_timer #(
    parameter int DEAD_CYC = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_in,
    output logic dir_q,
    output logic dead
);
    localparam int CW = $clog2(DEAD_CYC + 1);

    logic [CW-1:0] dead_cnt;

    // Track direction and run the dead-window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= 1'b0;
            dead_cnt <= '0;
        end else begin
            dir_q <= dir_in;
            if (dir_in != dir_q)
                dead_cnt <= CW'(DEAD_CYC);
            else if (dead_cnt != '0)
                dead_cnt <= dead_cnt - CW'(1);
        end
    end

    assign dead = (dead_cnt != '0);

endmodule

// File: rtl/chop_bridge.sv
// Control for one H-bridge.
// It registers the level code and selects the comparator trip that belongs to
// it. It holds a sink latch that the period start sets and the selected trip
// clears, and it forms the four gate enables. A zero code or an open dead window
// forces every gate off. A zero code also clears the sink latch.
// Assumes the trip inputs are already synchronous to clk.
module chop_bridge
    import chop_pkg::*;
#(
    parameter int DEAD_CYC = 750
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir_in,
    input  logic [1:0] lvl_in,
    input  logic [2:0] trip_in,
    input  logic       start,
    output gate_t      gate,
    output logic       idle
);
    logic [1:0] lvl_q;
    logic       sink_on;
    logic       trip_sel;
    logic       dir_q;
    logic       dead;

    chop_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_in (dir_in),
        .dir_q  (dir_q),
        .dead   (dead)
    );

    // Register the requested level code.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= LVL_OFF;
        else        lvl_q <= lvl_in;
    end

    // Pick the comparator that matches the current level.
    always_comb begin
        case (lvl_q)
            LVL_HOLD:  trip_sel = trip_in[0];
            LVL_NORM:  trip_sel = trip_in[1];
            LVL_BOOST: trip_sel = trip_in[2];
            default:   trip_sel = 1'b0;
        endcase
    end

    // Sink latch: a zero code clears it, a period start sets it, a trip ends it.
    always_ff @(posedge clk) begin
        if (!rst_n)                sink_on <= 1'b0;
        else if (lvl_q == LVL_OFF) sink_on <= 1'b0;
        else if (start)            sink_on <= 1'b1;
        else if (trip_sel)         sink_on <= 1'b0;
    end

    // Gate pattern from direction, sink latch, dead window and level.
    always_comb begin
        gate = '0;
        if (lvl_q != LVL_OFF && !dead) begin
            gate[G_HI_X1] = dir_q;
            gate[G_HI_X2] = !dir_q;
            gate[G_LO_X2] = dir_q  && sink_on;
            gate[G_LO_X1] = !dir_q && sink_on;
        end
    end

    assign idle = (lvl_q == LVL_OFF);

endmodule

// File: rtl/chopper_pair_ctrl.sv
// Top level of the dual-bridge chopper current controller.
// One period-start generator serves two bridge controllers, which a generate
// loop creates. The global inhibit follows the registered level codes, and it
// is high when both bridges are idle.
// Assumes the oscillator strobe is one clock wide and synchronous.
module chopper_pair_ctrl
    import chop_pkg::*;
#(
    parameter int OFFSET_CYC = 5000,
    parameter int DEAD_CYC   = 750
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       dir_a,
    input  logic [1:0] lvl_a,
    input  logic [2:0] trip_a,
    input  logic       dir_b,
    input  logic [1:0] lvl_b,
    input  logic [2:0] trip_b,
    output logic [3:0] gate_a,
    output logic [3:0] gate_b,
    output logic       inhibit
);
    localparam int NB = 2;

    logic [1:0]       start_pulse;
    logic [NB-1:0]    dir_v;
    logic [1:0]       lvl_v  [NB];
    logic [2:0]       trip_v [NB];
    gate_t            gate_v [NB];
    logic [NB-1:0]    idle_v;

    assign dir_v     = {dir_b, dir_a};
    assign lvl_v[0]  = lvl_a;
    assign lvl_v[1]  = lvl_b;
    assign trip_v[0] = trip_a;
    assign trip_v[1] = trip_b;

    chop_phaser #(.OFFSET_CYC(OFFSET_CYC)) u_phaser (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_tick    (osc_tick),
        .start_pulse (start_pulse)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bridge
        chop_bridge #(.DEAD_CYC(DEAD_CYC)) u_bridge (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir_in  (dir_v[b]),
            .lvl_in  (lvl_v[b]),
            .trip_in (trip_v[b]),
            .start   (start_pulse[b]),
            .gate    (gate_v[b]),
            .idle    (idle_v[b])
        );
    end

    assign gate_a  = gate_v[0];
    assign gate_b  = gate_v[1];
    assign inhibit = &idle_v;

endmodule

// File: rtl/chopper_pair_checker.sv
// Property checker for chopper_pair_ctrl, attached with bind.
// It observes the ports and the internal period-start pulses.
module chopper_pair_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       dir_a,
    input logic [1:0] lvl_a,
    input logic [2:0] trip_a,
    input logic       dir_b,
    input logic [1:0] lvl_b,
    input logic [2:0] trip_b,
    input logic [3:0] gate_a,
    input logic [3:0] gate_b,
    input logic       inhibit,
    input logic [1:0] start_pulse
);
    logic sel_a;
    logic sel_b;

    // Comparator that each bridge's present code refers to.
    always_comb begin
        sel_a = (lvl_a == 2'b01) ? trip_a[0] : (lvl_a == 2'b10) ? trip_a[1] :
                (lvl_a == 2'b11) ? trip_a[2] : 1'b0;
        sel_b = (lvl_b == 2'b01) ? trip_b[0] : (lvl_b == 2'b10) ? trip_b[1] :
                (lvl_b == 2'b11) ? trip_b[2] : 1'b0;
    end

    // R5: no leg conducts high and low together
    a_r5_leg_safe_a: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_a[0] && gate_a[2]) && !(gate_a[1] && gate_a[3]) && $countones(gate_a) <= 2);
    a_r5_leg_safe_b: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_b[0] && gate_b[2]) && !(gate_b[1] && gate_b[3]) && $countones(gate_b) <= 2);

    // R3: inhibit means every gate off
    a_r3_inhibit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> (gate_a == 4'b0 && gate_b == 4'b0));

    // R4: zero code blanks the bridge on the next cycle
    a_r4_zero_code_a: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_a == 2'b00) |=> (gate_a == 4'b0));
    a_r4_zero_code_b: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_b == 2'b00) |=> (gate_b == 4'b0));

    // R6: selected trip without a period start cuts the low side
    a_r6_trip_cut_a: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(lvl_a) && sel_a && !start_pulse[0]) |=> (gate_a[3:2] == 2'b00));
    a_r6_trip_cut_b: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(lvl_b) && sel_b && !start_pulse[1]) |=> (gate_b[3:2] == 2'b00));

    // R7: a direction change opens the dead window
    a_r7_dead_a: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dir_a != $past(dir_a)) |=> (gate_a == 4'b0));
    a_r7_dead_b: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dir_b != $past(dir_b)) |=> (gate_b == 4'b0));

endmodule

bind chopper_pair_ctrl chopper_pair_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir_a       (dir_a),
    .lvl_a       (lvl_a),
    .trip_a      (trip_a),
    .dir_b       (dir_b),
    .lvl_b       (lvl_b),
    .trip_b      (trip_b),
    .gate_a      (gate_a),
    .gate_b      (gate_b),
    .inhibit     (inhibit),
    .start_pulse (start_pulse)
);

// File: tb/test_chopper_pair_ctrl.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each task checking its own results.
// Inputs change on the falling edge, and outputs are sampled on the falling edge.
module test_chopper_pair_ctrl;
    localparam int OFFS = 20;
    localparam int DEAD = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       dir_a = 1'b0, dir_b = 1'b0;
    logic [1:0] lvl_a = 2'b00, lvl_b = 2'b00;
    logic [2:0] trip_a = 3'b000, trip_b = 3'b000;
    logic [3:0] gate_a, gate_b;
    logic       inhibit;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    chopper_pair_ctrl #(.OFFSET_CYC(OFFS), .DEAD_CYC(DEAD)) i_chopper_pair_ctrl (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .dir_a(dir_a), .lvl_a(lvl_a), .trip_a(trip_a),
        .dir_b(dir_b), .lvl_b(lvl_b), .trip_b(trip_b),
        .gate_a(gate_a), .gate_b(gate_b), .inhibit(inhibit)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Strobe the oscillator for one clock. Returns at the next falling edge.
    task automatic tick();
        osc_tick = 1'b1;
        step(1);
        osc_tick = 1'b0;
    endtask

    task automatic t_reset();
        step(3);
        check("R3", "inhibit in reset", 32'(inhibit), 32'd1);
        check("R3", "gates in reset", 32'({gate_b, gate_a}), 32'h0);
        rst_n = 1'b1;
        step(2);
        check("R3", "inhibit with zero codes", 32'(inhibit), 32'd1);
    endtask

    task automatic t_basic_a();
        lvl_a = 2'b10; dir_a = 1'b1;
        step(DEAD + 2);
        check("R5", "A high X1 only", 32'(gate_a), 32'h1);
        check("R3", "inhibit released", 32'(inhibit), 32'd0);
        check("R4", "idle B stays off", 32'(gate_b), 32'h0);
        tick();
        check("R2", "A sink not yet", 32'(gate_a), 32'h1);
        step(1);
        check("R2", "A sink on", 32'(gate_a), 32'h9);
        step(30);
    endtask

    task automatic t_offset();
        lvl_b = 2'b01; dir_b = 1'b0;
        step(2);
        check("R5", "B high X2 only", 32'(gate_b), 32'h2);
        tick();
        step(OFFS);
        check("R2", "B sink before offset", 32'(gate_b), 32'h2);
        step(1);
        check("R2", "B sink after offset", 32'(gate_b), 32'h6);
        step(5);
    endtask

    task automatic t_trip();
        trip_a = 3'b101;
        step(1);
        check("R1", "unselected trips ignored", 32'(gate_a), 32'h9);
        trip_a = 3'b010;
        step(1);
        check("R6", "selected trip cuts sink", 32'(gate_a), 32'h1);
        trip_a = 3'b000;
        step(4);
        check("R6", "cut stays latched", 32'(gate_a), 32'h1);
        tick();
        step(1);
        check("R2", "next period re-enables", 32'(gate_a), 32'h9);
        lvl_a = 2'b11;
        step(1);
        trip_a = 3'b010;
        step(2);
        check("R1", "boost ignores normal trip", 32'(gate_a), 32'h9);
        trip_a = 3'b100;
        step(1);
        check("R1", "boost trip cuts", 32'(gate_a), 32'h1);
    endtask

    task automatic t_start_wins();
        step(3);
        tick();
        step(1);
        check("R8", "start beats trip", 32'(gate_a), 32'h9);
        step(1);
        check("R8", "held trip cuts next", 32'(gate_a), 32'h1);
        trip_a = 3'b000;
        step(OFFS + 5);
    endtask

    task automatic t_dead();
        int bad;
        tick();
        step(1);
        check("R7", "sink on before reversal", 32'(gate_a), 32'h9);
        dir_a = 1'b0;
        bad = 0;
        for (int i = 0; i < DEAD; i++) begin
            step(1);
            if (gate_a != 4'h0) bad++;
        end
        check("R7", "dead window cycles with gates on", 32'(bad), 32'd0);
        step(1);
        check("R7", "resume reversed", 32'(gate_a), 32'h6);
        dir_a = 1'b1;
        step(1);
        dir_a = 1'b0;
        step(DEAD);
        check("R7", "glitch restarts window", 32'(gate_a), 32'h0);
        step(1);
        check("R7", "resume after glitch", 32'(gate_a), 32'h6);
        step(OFFS + 5);
    endtask

    task automatic t_zero();
        lvl_a = 2'b00;
        step(1);
        check("R4", "zero code blanks A", 32'(gate_a), 32'h0);
        check("R3", "no inhibit with B active", 32'(inhibit), 32'd0);
        lvl_a = 2'b10;
        step(1);
        check("R4", "sink cleared after zero", 32'(gate_a), 32'h2);
        check("R4", "B unaffected", 32'(gate_b), 32'h6);
        step(3);
        check("R4", "sink waits for period", 32'(gate_a), 32'h2);
    endtask

    task automatic t_inhibit();
        lvl_a = 2'b00; lvl_b = 2'b00;
        step(1);
        check("R3", "inhibit set", 32'(inhibit), 32'd1);
        check("R3", "all gates off", 32'({gate_b, gate_a}), 32'h0);
        tick();
        step(3);
        check("R3", "tick ignored in inhibit", 32'({gate_b, gate_a}), 32'h0);
        lvl_a = 2'b10;
        step(1);
        check("R3", "inhibit cleared", 32'(inhibit), 32'd0);
        check("R4", "resume without sink", 32'(gate_a), 32'h2);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic_a();
        t_offset();
        t_trip();
        t_start_wins();
        t_dead();
        t_zero();
        t_inhibit();
        step(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule